// File: doc/BRIEF.md
# Snooping Four-State Cache Line Coherence Controller

This block holds the coherence state of every line of a write-back, write-allocate cache on a shared snooping bus. Each line is Invalid, Exclusive (clean, sole copy), Shared (clean, other copies possible) or Modified (dirty, sole copy). Processor requests carry a line index and a read/write flag. A request to an Invalid line is a miss; any other request is a hit. From the line's current state the block decides whether a bus transaction is needed and which one. It then moves the line to its next state on the clock edge.

The bus is atomic: one transaction per cycle. When this cache issues a read miss, the other caches answer in the same cycle on a wired-OR "copy exists" line (`shared_in`). That answer decides whether the fill lands in Exclusive or Shared. When another cache's transaction is snooped, the block reports whether it holds a copy, moves the line, and says whether it must drive the data and write the line back.

Clean sharers decide among themselves who supplies the data through a daisy chain. The first cache in the chain that holds a copy supplies it, and every cache further down stays quiet. While a snooped transaction is present the processor port is stalled.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads as Invalid; the state encoding on `cpu_state` is Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A processor read to an Invalid line puts a read-miss request (op code 1) on the bus that cycle, and the line becomes Exclusive when `shared_in` is low.
- R3: A processor read miss during which `shared_in` is high fills the line in Shared.
- R4: A processor write to an Exclusive line makes it Modified and issues no bus request.
- R5: A processor write to a Shared line issues an invalidate request (op code 3) and makes the line Modified.
- R6: A processor write to an Invalid line issues a write-miss request (op code 2) and fills the line in Modified.
- R7: Reads or writes to a Modified line, and reads to Exclusive or Shared lines, issue no bus request and leave the state unchanged.
- R8: A snooped read miss (op code 1) that finds the line valid drives `shared_out` high in that cycle and leaves the line Shared; on an Invalid line `shared_out` stays low.
- R9: A snooped write miss (op 2) or invalidate (op 3) turns a valid line Invalid; any snoop on an Invalid line changes nothing.
- R10: A snooped read miss or write miss that finds the line Modified raises both `supply_data` and `writeback` in the same cycle as the state change.
- R11: On a snooped read miss to a clean valid line, `supply_data` is high only when `supply_chain_in` is low; `supply_chain_out` is high when `supply_chain_in` is high or this cache supplies.
- R12: While `snoop_valid` is high, `cpu_ready` is low and a processor request has no effect on bus requests or line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IDXW | Line index of the processor request |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_state | output | 2 | Current state of line `cpu_idx` |
| shared_in | input | 1 | Copy-exists response from other caches |
| bus_req_valid | output | 1 | This cache drives a bus transaction |
| bus_req_op | output | 2 | 1 read miss, 2 write miss, 3 invalidate |
| bus_req_idx | output | IDXW | Line index of the bus transaction |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_op | input | 2 | Op code of the snooped transaction |
| snoop_idx | input | IDXW | Line index of the snooped transaction |
| supply_chain_in | input | 1 | An earlier cache already supplies |
| supply_chain_out | output | 1 | This or an earlier cache supplies |
| shared_out | output | 1 | This cache holds a copy for a snooped read miss |
| supply_data | output | 1 | This cache drives the line data |
| writeback | output | 1 | Dirty line must be written to memory |

## Verification
The bench covers each entry state for every event class. A controller that ignored `shared_in` would fill in the wrong clean state. One that invalidated on a write to Exclusive would add bus traffic. One that treated Shared like Exclusive would leave stale copies behind. On the snoop side, a dirty owner that moved to Shared without raising `writeback` would lose data. A clean sharer that ignored `supply_chain_in` would collide with an upstream supplier on the data bus. A snoop to an Invalid line must not wake the line or claim a copy. A processor request presented during a snoop must leave both bus and state untouched.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 16,
  localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  input  logic            cpu_write,
  input  logic [IDXW-1:0] cpu_idx,
  output logic            cpu_ready,
  output logic [1:0]      cpu_state,
  input  logic            shared_in,
  output logic            bus_req_valid,
  output logic [1:0]      bus_req_op,
  output logic [IDXW-1:0] bus_req_idx,
  input  logic            snoop_valid,
  input  logic [1:0]      snoop_op,
  input  logic [IDXW-1:0] snoop_idx,
  input  logic            supply_chain_in,
  output logic            supply_chain_out,
  output logic            shared_out,
  output logic            supply_data,
  output logic            writeback
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_INV = 2'd3;

  logic [1:0] st_q [LINES];
  logic [1:0] cpu_st, snp_st;
  logic       cpu_go, snp_hit;

  assign cpu_st    = st_q[cpu_idx];
  assign snp_st    = st_q[snoop_idx];
  assign cpu_ready = !snoop_valid;
  assign cpu_go    = cpu_valid && cpu_ready;
  assign cpu_state = cpu_st;

  always_comb begin
    bus_req_op = OP_NONE;
    if (cpu_go) begin
      if (cpu_st == ST_I)
        bus_req_op = cpu_write ? OP_WR : OP_RD;
      else if (cpu_write && cpu_st == ST_S)
        bus_req_op = OP_INV;
    end
  end
  assign bus_req_valid = bus_req_op != OP_NONE;
  assign bus_req_idx   = cpu_idx;

  assign snp_hit          = snoop_valid && snp_st != ST_I && snoop_op != OP_NONE;
  assign shared_out       = snp_hit && snoop_op == OP_RD;
  assign writeback        = snp_hit && snp_st == ST_M && snoop_op != OP_INV;
  assign supply_data      = writeback || (shared_out && !supply_chain_in);
  assign supply_chain_out = supply_chain_in || supply_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (snp_hit) begin
      st_q[snoop_idx] <= (snoop_op == OP_RD) ? ST_S : ST_I;
    end else if (cpu_go) begin
      if (cpu_write)
        st_q[cpu_idx] <= ST_M;
      else if (cpu_st == ST_I)
        st_q[cpu_idx] <= shared_in ? ST_S : ST_E;
    end
  end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_valid,
  input logic            cpu_write,
  input logic [IDXW-1:0] cpu_idx,
  input logic            cpu_ready,
  input logic [1:0]      cpu_state,
  input logic            shared_in,
  input logic            bus_req_valid,
  input logic [1:0]      bus_req_op,
  input logic            snoop_valid,
  input logic [1:0]      snoop_op,
  input logic [IDXW-1:0] snoop_idx,
  input logic            supply_chain_in,
  input logic            supply_chain_out,
  input logic            shared_out,
  input logic            supply_data,
  input logic            writeback
);
  // R2
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_write && cpu_state == 2'd0)
      |=> (cpu_idx != $past(cpu_idx) || cpu_state == ($past(shared_in) ? 2'd1 : 2'd2)));
  // R6
  write_to_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_write) |=> (cpu_idx != $past(cpu_idx) || cpu_state == 2'd3));
  // R9
  snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_op[1]) |=> (cpu_idx != $past(snoop_idx) || cpu_state == 2'd0));
  // R10
  wb_supplies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writeback |-> supply_data);
  // R11
  chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_chain_in && !writeback) |-> (!supply_data && supply_chain_out));
  // R8
  shared_only_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shared_out |-> (snoop_valid && snoop_op == 2'd1));
  // R12
  stall_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> !bus_req_valid);
  // R4
  no_inval_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_op == 2'd3) |-> (cpu_write && cpu_state == 2'd1));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
  .cpu_idx(cpu_idx), .cpu_ready(cpu_ready), .cpu_state(cpu_state),
  .shared_in(shared_in), .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op),
  .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_idx(snoop_idx),
  .supply_chain_in(supply_chain_in), .supply_chain_out(supply_chain_out),
  .shared_out(shared_out), .supply_data(supply_data), .writeback(writeback)
);

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
  localparam int LINES = 16;
  localparam int IDXW = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_write = 0, shared_in = 0;
  logic [IDXW-1:0] cpu_idx = '0, snoop_idx = '0, bus_req_idx;
  logic cpu_ready, bus_req_valid, snoop_valid = 0, supply_chain_in = 0;
  logic [1:0] cpu_state, bus_req_op, snoop_op = '0;
  logic supply_chain_out, shared_out, supply_data, writeback;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) u_mesi_line_ctrl (.*);

  typedef struct packed {
    logic bv; logic [1:0] bop; logic shr, sup, wb, cho, rdy; logic [1:0] st;
  } exp_t;
  typedef struct { string rq; exp_t e; } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic exp_t ex(bit bv, int bop, bit shr, bit sup, bit wb, bit cho, bit rdy, int st);
    return '{bv, 2'(bop), shr, sup, wb, cho, rdy, 2'(st)};
  endfunction

  task automatic step(string rq, bit cv, bit cw, int ci, bit sh,
                      bit sv, int sop, int si, bit chin, exp_t e);
    @(negedge clk);
    cpu_valid = cv; cpu_write = cw; cpu_idx = IDXW'(ci); shared_in = sh;
    snoop_valid = sv; snoop_op = 2'(sop); snoop_idx = IDXW'(si); supply_chain_in = chin;
    q.push_back('{rq, e});
  endtask

  task automatic look(string rq, int idx, int st);
    step(rq, 0, 0, idx, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 0, 0, 1, st));
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        exp_t got;
        it = q.pop_front();
        got = '{bus_req_valid, bus_req_op, shared_out, supply_data, writeback,
                supply_chain_out, cpu_ready, cpu_state};
        total++;
        if (got !== it.e) begin
          bad++;
          $display("FAIL %s got=%b expected=%b", it.rq, got, it.e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    look("R1 line 0 invalid after reset", 0, 0);
    look("R1 line 15 invalid after reset", 15, 0);
    step("R2 read miss issues op 1", 1, 0, 1, 0, 0, 0, 0, 0, ex(1, 1, 0, 0, 0, 0, 1, 0));
    look("R2 fill exclusive", 1, 2);
    step("R3 read miss shared answer", 1, 0, 2, 1, 0, 0, 0, 0, ex(1, 1, 0, 0, 0, 0, 1, 0));
    look("R3 fill shared", 2, 1);
    step("R4 write exclusive no bus", 1, 1, 1, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 0, 0, 1, 2));
    look("R4 exclusive to modified", 1, 3);
    step("R5 write shared invalidates", 1, 1, 2, 0, 0, 0, 0, 0, ex(1, 3, 0, 0, 0, 0, 1, 1));
    look("R5 shared to modified", 2, 3);
    step("R6 write miss issues op 2", 1, 1, 3, 0, 0, 0, 0, 0, ex(1, 2, 0, 0, 0, 0, 1, 0));
    look("R6 fill modified", 3, 3);
    step("R7 read modified no bus", 1, 0, 1, 1, 0, 0, 0, 0, ex(0, 0, 0, 0, 0, 0, 1, 3));
    step("R7 write modified no bus", 1, 1, 1, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 0, 0, 1, 3));
    look("R7 modified kept", 1, 3);
    step("R7 setup exclusive line 4", 1, 0, 4, 0, 0, 0, 0, 0, ex(1, 1, 0, 0, 0, 0, 1, 0));
    step("R7 read exclusive no bus", 1, 0, 4, 1, 0, 0, 0, 0, ex(0, 0, 0, 0, 0, 0, 1, 2));
    look("R7 exclusive kept", 4, 2);
    step("R7 setup shared line 5", 1, 0, 5, 1, 0, 0, 0, 0, ex(1, 1, 0, 0, 0, 0, 1, 0));
    step("R7 read shared no bus", 1, 0, 5, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 0, 0, 1, 1));
    look("R7 shared kept", 5, 1);
    step("R10 snoop read on modified", 0, 0, 1, 0, 1, 1, 1, 0, ex(0, 0, 1, 1, 1, 1, 0, 3));
    look("R8 modified to shared", 1, 1);
    step("R11 snoop read exclusive first in chain", 0, 0, 4, 0, 1, 1, 4, 0, ex(0, 0, 1, 1, 0, 1, 0, 2));
    look("R8 exclusive to shared", 4, 1);
    step("R11 snoop read shared chain taken", 0, 0, 5, 0, 1, 1, 5, 1, ex(0, 0, 1, 0, 0, 1, 0, 1));
    look("R8 shared kept on snoop read", 5, 1);
    step("R8 snoop read invalid line", 0, 0, 6, 0, 1, 1, 6, 0, ex(0, 0, 0, 0, 0, 0, 0, 0));
    step("R11 chain passes through invalid", 0, 0, 6, 0, 1, 1, 6, 1, ex(0, 0, 0, 0, 0, 1, 0, 0));
    look("R9 invalid line untouched", 6, 0);
    step("R10 snoop write on modified", 0, 0, 3, 0, 1, 2, 3, 0, ex(0, 0, 0, 1, 1, 1, 0, 3));
    look("R9 modified to invalid", 3, 0);
    step("R9 snoop invalidate on shared", 0, 0, 5, 0, 1, 3, 5, 0, ex(0, 0, 0, 0, 0, 0, 0, 1));
    look("R9 shared to invalid", 5, 0);
    step("R9 snoop write on shared", 0, 0, 4, 0, 1, 2, 4, 0, ex(0, 0, 0, 0, 0, 0, 0, 1));
    look("R9 line 4 invalid", 4, 0);
    step("R12 write stalled by snoop", 1, 1, 7, 0, 1, 1, 8, 0, ex(0, 0, 0, 0, 0, 0, 0, 0));
    look("R12 stalled write left line invalid", 7, 0);
    step("R12 read of modified during snoop", 1, 0, 2, 0, 1, 2, 9, 0, ex(0, 0, 0, 0, 0, 0, 0, 3));
    look("R12 line 2 still modified", 2, 3);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule